// File: doc/BRIEF.md
# Pipeline Register Interlock Unit

This unit sits at the issue point of a four-stage in-order pipeline (Iss, Ex1, Ex2, Wr). It detects read-after-write hazards and raises a stall until every source operand of the issuing instruction can be forwarded. It is not a plain load-use check. Each producer that is accepted at issue leaves a countdown against its destination register. Each source operand of a later instruction is then tested against that countdown. The test is adjusted by the stage in which the operand is consumed: very early (address base), early (shift amount), normal (ALU input in Ex2) or late (store data).

Result latency counts the cycles until a value can serve a consumer that needs it in Ex2. That latency is one for ALU results and two for loads. The other need classes shift it by +2, +1, 0 or -1 cycles. The number of stall cycles a back-to-back pair inserts is the adjusted latency minus one, floored at zero. Every bubble cycle between producer and consumer removes one cycle from that figure. Register 15 is the program counter and never takes part in a comparison. A pipeline-wide freeze input stops the countdowns and blocks issue.

Top module: `pipe_interlock`

## Requirements
- R1: An ALU producer (dst_load_i=0) followed directly by a consumer that reads its destination with need code 2 (normal) gives 0 stall cycles.
- R2: A load producer (dst_load_i=1) followed directly by a need code 2 consumer of its destination gives 1 stall cycle.
- R3: With need code 1 (early), a directly following consumer gives 2 stall cycles after a load and 1 after an ALU producer.
- R4: With need code 0 (very early), a directly following consumer gives 3 stall cycles after a load and 2 after an ALU producer; no stall run is ever longer than 3 advancing cycles.
- R5: With need code 3 (late), a directly following consumer gives 0 stall cycles after either producer class.
- R6: Register 15 never causes a stall: it is neither recorded as a destination nor compared as a source.
- R7: With several matching operands the stall lasts for the longest requirement among them, and each register is judged against its youngest accepted producer.
- R8: While hold_i=1 no instruction is accepted and no countdown moves, so the stall that remains after the hold is released equals the one seen without the hold.
- R9: Each cycle between producer and consumer in which the pipeline advances removes one stall cycle, down to zero.
- R10: Reset clears every pending producer, so no source causes a stall afterwards.
- R11: stall_o is 0 whenever issue_vld_i=0 or no source is valid. An instruction is accepted in a cycle with issue_vld_i=1, stall_o=0 and hold_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Pipeline-wide freeze: no issue, countdowns held |
| issue_vld_i | input | 1 | An instruction is presented for issue |
| src_vld_i | input | NUM_SRC | Per-operand valid |
| src_reg_i | input | NUM_SRC x REG_W | Per-operand register number |
| src_need_i | input | NUM_SRC x 2 | Per-operand need code: 0 very early, 1 early, 2 normal, 3 late |
| dst_vld_i | input | 1 | Instruction writes a register |
| dst_reg_i | input | REG_W | Destination register number |
| dst_load_i | input | 1 | Producer class: 1 load, 0 ALU |
| stall_o | output | 1 | Hold the presented instruction in Iss this cycle |

## Verification
The stall-length bound assumes that no new producer is accepted during a stall run. The unit's own accept rule guarantees this, and the bound holds whatever the consumer presents. The register-15 property assumes that register 15 is only ever the program counter. The stimulus keeps each presented instruction stable until it is accepted. It sweeps producer class, need code and gap length, with every pending entry drained before each pair, so the expected count follows directly from the latency arithmetic.

// File: rtl/pil_pkg.sv
package pil_pkg;
  typedef enum logic [1:0] {
    NEED_VEARLY = 2'd0,
    NEED_EARLY  = 2'd1,
    NEED_NORMAL = 2'd2,
    NEED_LATE   = 2'd3
  } need_e;

  // countdown bias so the very-early adjustment never goes below zero
  localparam int unsigned VE_BIAS = 2;
endpackage

// File: rtl/pil_scoreboard.sv
module pil_scoreboard #(
  parameter int unsigned REG_W    = 4,
  parameter int unsigned NUM_REG  = 15,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned LAT_ALU  = 1,
  parameter int unsigned LAT_LOAD = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           adv_i,
  input  logic                           wr_en_i,
  input  logic [REG_W-1:0]               wr_reg_i,
  input  logic                           wr_load_i,
  output logic [NUM_REG-1:0][CNT_W-1:0]  rem_o
);
  localparam logic [CNT_W-1:0] START_ALU  = CNT_W'(LAT_ALU  + pil_pkg::VE_BIAS);
  localparam logic [CNT_W-1:0] START_LOAD = CNT_W'(LAT_LOAD + pil_pkg::VE_BIAS);

  for (genvar r = 0; r < NUM_REG; r++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_reg_i == REG_W'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   rem_o[r] <= '0;
      else if (hit)                  rem_o[r] <= wr_load_i ? START_LOAD : START_ALU;
      else if (adv_i && rem_o[r] != '0) rem_o[r] <= rem_o[r] - 1'b1;
    end
  end
endmodule

// File: rtl/pil_opnd_chk.sv
module pil_opnd_chk #(
  parameter int unsigned REG_W   = 4,
  parameter int unsigned NUM_REG = 15,
  parameter int unsigned CNT_W   = 3
) (
  input  logic                           vld_i,
  input  logic [REG_W-1:0]               reg_i,
  input  logic [1:0]                     need_i,
  input  logic [NUM_REG-1:0][CNT_W-1:0]  rem_i,
  output logic                           stall_o
);
  import pil_pkg::*;

  logic [CNT_W-1:0] rem_sel;
  logic [CNT_W:0]   thr;

  always_comb begin
    rem_sel = '0;
    for (int r = 0; r < NUM_REG; r++)
      if (reg_i == REG_W'(r)) rem_sel = rem_i[r];
  end

  // stall while remaining countdown exceeds the cycle the operand is consumed
  always_comb begin
    case (need_e'(need_i))
      NEED_VEARLY: thr = (CNT_W+1)'(VE_BIAS - 1);
      NEED_EARLY:  thr = (CNT_W+1)'(VE_BIAS);
      NEED_NORMAL: thr = (CNT_W+1)'(VE_BIAS + 1);
      default:     thr = (CNT_W+1)'(VE_BIAS + 2);
    endcase
  end

  assign stall_o = vld_i && ({1'b0, rem_sel} > thr);
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock #(
  parameter int unsigned NUM_SRC  = 3,
  parameter int unsigned REG_W    = 4,
  parameter int unsigned LAT_ALU  = 1,
  parameter int unsigned LAT_LOAD = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            hold_i,
  input  logic                            issue_vld_i,
  input  logic [NUM_SRC-1:0]              src_vld_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   src_reg_i,
  input  logic [NUM_SRC-1:0][1:0]         src_need_i,
  input  logic                            dst_vld_i,
  input  logic [REG_W-1:0]                dst_reg_i,
  input  logic                            dst_load_i,
  output logic                            stall_o
);
  localparam int unsigned NUM_REG = (1 << REG_W) - 1;
  localparam logic [REG_W-1:0] PC_REG = REG_W'(NUM_REG);
  localparam int unsigned CNT_W = $clog2(LAT_LOAD + pil_pkg::VE_BIAS + 1);

  logic [NUM_REG-1:0][CNT_W-1:0] rem;
  logic [NUM_SRC-1:0]            op_stall;
  logic                          accept;
  logic                          wr_en;

  assign accept = issue_vld_i && !stall_o && !hold_i;
  assign wr_en  = accept && dst_vld_i && (dst_reg_i != PC_REG);

  pil_scoreboard #(
    .REG_W(REG_W), .NUM_REG(NUM_REG), .CNT_W(CNT_W),
    .LAT_ALU(LAT_ALU), .LAT_LOAD(LAT_LOAD)
  ) sb_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (!hold_i),
    .wr_en_i  (wr_en),
    .wr_reg_i (dst_reg_i),
    .wr_load_i(dst_load_i),
    .rem_o    (rem)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    pil_opnd_chk #(.REG_W(REG_W), .NUM_REG(NUM_REG), .CNT_W(CNT_W)) chk_i (
      .vld_i  (src_vld_i[s] && (src_reg_i[s] != PC_REG)),
      .reg_i  (src_reg_i[s]),
      .need_i (src_need_i[s]),
      .rem_i  (rem),
      .stall_o(op_stall[s])
    );
  end

  assign stall_o = issue_vld_i && (|op_stall);
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk #(
  parameter int unsigned NUM_SRC  = 3,
  parameter int unsigned REG_W    = 4,
  parameter int unsigned LAT_LOAD = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          hold_i,
  input logic                          issue_vld_i,
  input logic [NUM_SRC-1:0]            src_vld_i,
  input logic [NUM_SRC-1:0][REG_W-1:0] src_reg_i,
  input logic                          stall_o
);
  localparam logic [REG_W-1:0] PC_REG = {REG_W{1'b1}};
  localparam logic [3:0] MAX_STALL = 4'(LAT_LOAD + pil_pkg::VE_BIAS - 1);

  logic       only_pc;
  logic [3:0] run_cnt;

  always_comb begin
    only_pc = 1'b1;
    for (int s = 0; s < NUM_SRC; s++)
      if (src_vld_i[s] && src_reg_i[s] != PC_REG) only_pc = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               run_cnt <= '0;
    else if (!stall_o)                         run_cnt <= '0;
    else if (!hold_i && run_cnt != 4'hf)       run_cnt <= run_cnt + 1'b1;
  end

  AST_STALL_NEEDS_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> issue_vld_i); // R11
  AST_NO_SRC_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_vld_i == '0) |-> !stall_o); // R11
  AST_PC_NEVER_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    only_pc |-> !stall_o); // R6
  AST_STALL_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= MAX_STALL); // R4
endmodule

bind pipe_interlock pipe_interlock_chk #(
  .NUM_SRC(NUM_SRC), .REG_W(REG_W), .LAT_LOAD(LAT_LOAD)
) chk_bind_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_i     (hold_i),
  .issue_vld_i(issue_vld_i),
  .src_vld_i  (src_vld_i),
  .src_reg_i  (src_reg_i),
  .stall_o    (stall_o)
);

// File: tb/pipe_interlock_tb_top.sv
module pipe_interlock_tb_top;
  localparam int NUM_SRC = 3;
  localparam int REG_W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hold_i = 1'b0;
  logic issue_vld_i = 1'b0;
  logic [NUM_SRC-1:0] src_vld_i = '0;
  logic [NUM_SRC-1:0][REG_W-1:0] src_reg_i = '0;
  logic [NUM_SRC-1:0][1:0] src_need_i = '0;
  logic dst_vld_i = 1'b0;
  logic [REG_W-1:0] dst_reg_i = '0;
  logic dst_load_i = 1'b0;
  logic stall_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pipe_interlock #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) dut_i (.*);

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // present one instruction, keep it until accepted, return advancing stall cycles
  task automatic present(input logic [1:0] vld, input logic [3:0] r0, input logic [1:0] n0,
                         input logic [3:0] r1, input logic [1:0] n1,
                         input logic dv, input logic [3:0] dr, input logic dl,
                         input int hold_cyc, output int st);
    @(negedge clk_i);
    issue_vld_i = 1'b1;
    src_vld_i = {1'b0, vld};
    src_reg_i[0] = r0; src_need_i[0] = n0;
    src_reg_i[1] = r1; src_need_i[1] = n1;
    src_reg_i[2] = 4'd0; src_need_i[2] = 2'd2;
    dst_vld_i = dv; dst_reg_i = dr; dst_load_i = dl;
    hold_i = (hold_cyc > 0);
    for (int h = 0; h < hold_cyc; h++) @(negedge clk_i);
    hold_i = 1'b0;
    st = 0;
    for (int g = 0; g < 20; g++) begin
      #1;
      if (!stall_o) break;
      st++;
      @(negedge clk_i);
    end
    @(posedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      issue_vld_i = 1'b0;
      src_vld_i = '0;
    end
  endtask

  task automatic produce(input logic [3:0] dr, input logic dl);
    int st;
    present(2'b00, 4'd0, 2'd2, 4'd0, 2'd2, 1'b1, dr, dl, 0, st);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int st;
    int exp;
    int idx;
    string tag;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10: nothing pending after reset
    present(2'b01, 4'd1, 2'd0, 4'd0, 2'd2, 1'b0, 4'd0, 1'b0, 0, st);
    chk(st, 0, "R10 after reset");

    // sweep producer class x need code x gap
    idx = 0;
    for (int l = 0; l < 2; l++)
      for (int n = 0; n < 4; n++)
        for (int g = 0; g < 4; g++) begin
          logic [3:0] rr;
          int lat, adj;
          rr = 4'((idx % 14) + 1);
          idx++;
          idle(6);
          produce(rr, l[0]);
          idle(g);
          present(2'b01, rr, 2'(n), 4'd0, 2'd2, 1'b0, 4'd0, 1'b0, 0, st);
          lat = (l == 1) ? 2 : 1;
          adj = 2 - n;
          exp = lat + adj - 1 - g;
          if (exp < 0) exp = 0;
          if (g > 0) tag = "R9 gap";
          else if (n == 3) tag = "R5 late";
          else if (n == 0) tag = "R4 very early";
          else if (n == 1) tag = "R3 early";
          else if (l == 1) tag = "R2 load normal";
          else tag = "R1 alu normal";
          chk(st, exp, $sformatf("%s load=%0d need=%0d gap=%0d", tag, l, n, g));
        end

    // R6: register 15 as destination and source
    idle(6);
    produce(4'd15, 1'b1);
    present(2'b01, 4'd15, 2'd0, 4'd0, 2'd2, 1'b0, 4'd0, 1'b0, 0, st);
    chk(st, 0, "R6 pc load then very early pc read");

    // R7: maximum over operands
    idle(6);
    produce(4'd4, 1'b1);
    produce(4'd5, 1'b0);
    present(2'b11, 4'd5, 2'd2, 4'd4, 2'd0, 1'b0, 4'd0, 1'b0, 0, st);
    chk(st, 2, "R7 max of operands");

    // R7: youngest producer wins
    idle(6);
    produce(4'd6, 1'b0);
    produce(4'd6, 1'b1);
    present(2'b01, 4'd6, 2'd2, 4'd0, 2'd2, 1'b0, 4'd0, 1'b0, 0, st);
    chk(st, 1, "R7 youngest producer");

    // R8: hold freezes countdown
    idle(6);
    produce(4'd7, 1'b1);
    present(2'b01, 4'd7, 2'd1, 4'd0, 2'd2, 1'b0, 4'd0, 1'b0, 3, st);
    chk(st, 2, "R8 hold keeps countdown");

    // R11: no stall without issue_vld_i
    idle(6);
    produce(4'd8, 1'b1);
    @(negedge clk_i);
    issue_vld_i = 1'b0;
    src_vld_i = 3'b001; src_reg_i[0] = 4'd8; src_need_i[0] = 2'd0;
    #1;
    chk(int'(stall_o), 0, "R11 no stall without issue");
    issue_vld_i = 1'b1;
    #1;
    chk(int'(stall_o), 1, "R11 stall with issue");
    issue_vld_i = 1'b0;

    // R10: reset mid-flight clears pending load
    idle(2);
    produce(4'd2, 1'b1);
    @(negedge clk_i);
    issue_vld_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    present(2'b01, 4'd2, 2'd0, 4'd0, 2'd2, 1'b0, 4'd0, 1'b0, 0, st);
    chk(st, 0, "R10 reset clears pending");

    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule